// File: doc/BRIEF.md
# Histogram-Match Window Selector and Tracker

This block makes the per-frame decision in a visual tracking loop. Earlier stages stream the histogram bins of several candidate search windows into it. Each beat carries a window id, a bin index, a bin value and the window's position. While the bins arrive, the block keeps one dissimilarity score per window. In the normal mode a bin adds the absolute difference between the stored reference bin and the candidate bin. In the trained mode a bin adds its weight when the candidate bin is at or below the stored bin, and subtracts the weight otherwise.

When the frame-end strobe arrives, the block picks the window with the smallest score and compares that score with an acceptance threshold. If the window is accepted, the block makes it the target. It replaces the reference histogram with the window's bins (normal mode only), predicts the next position with a constant-velocity rule, and converts the offset of the target from the image centre into signed pan and tilt step counts. If no window is accepted, the target is lost. The block then holds its position, stops the motors and widens a search radius on every lost frame, until a window is accepted again.

The reference histogram is loaded through the bin stream, and an init strobe sets the start position. Histogram generation and motor pulse generation sit outside this block.

Top module: `hist_track_top`

## Requirements
- R1: In the normal mode (trainMode=0), the score of a window is the sum, over every bin beat sent for it in the frame, of |reference bin − candidate bin|. Scores start at zero on each frame.
- R2: The winner is the window with the smallest score. Among equal scores, the lowest window id wins. A window that received no bin beat in the frame is never a candidate.
- R3: A frame is accepted only if at least one window received bins and the smallest score is strictly less than `thresh`, compared as signed values. On acceptance, tgtX/tgtY take the winner's position, searchMode becomes 0 and searchRadius returns to BASE_R.
- R4: On an accepted frame in the normal mode, the winner's bins replace the reference histogram, and the next frame scores against them.
- R5: On a rejected frame, tgtX/tgtY and predX/predY hold, searchMode becomes 1, panStep and tiltStep become 0, and searchRadius grows by INC_R, saturating at MAX_R.
- R6: On acceptance, predX = 2·newX − oldX and predY = 2·newY − oldY, where old is the target before the frame. After an init, the prediction equals the init position.
- R7: On acceptance, panStep = (tgtX − CENTER_X) / 2^STEP_SHIFT and tiltStep = (tgtY − CENTER_Y) / 2^STEP_SHIFT. Both are signed and round toward zero.
- R8: In the trained mode (trainMode=1), a bin adds binWeight when the candidate bin ≤ the reference bin and subtracts it otherwise. The reference is not replaced on acceptance.
- R9: The results of a frame appear in the cycle after frameEnd is sampled, with decValid high for that one cycle. Bin beats presented in the frameEnd cycle are ignored.
- R10: After reset, the target, prediction and steps are 0, searchMode is 0 and searchRadius is BASE_R. initStrobe sets the target and prediction to initX/initY, with the same mode, radius and steps. A beat with refWrite=1 writes binVal into reference bin binIdx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| initStrobe | input | 1 | Load start position |
| initX | input | POS_W | Start x (signed) |
| initY | input | POS_W | Start y (signed) |
| refWrite | input | 1 | Beat writes the reference instead of scoring |
| binValid | input | 1 | Bin beat present |
| binWin | input | log2(NUM_WIN) | Window id of the beat |
| binIdx | input | log2(NUM_BINS) | Bin index |
| binVal | input | BIN_W | Bin value |
| binWeight | input | BIN_W | Bin weight for the trained mode |
| binX | input | POS_W | Window x position (signed) |
| binY | input | POS_W | Window y position (signed) |
| frameEnd | input | 1 | End of frame, triggers the decision |
| trainMode | input | 1 | 0 = absolute difference, 1 = weighted sign |
| thresh | input | SCORE_W | Acceptance threshold (signed) |
| decValid | output | 1 | One-cycle pulse when new results are ready |
| tgtX | output | POS_W | Target x |
| tgtY | output | POS_W | Target y |
| predX | output | POS_W | Predicted next x |
| predY | output | POS_W | Predicted next y |
| searchMode | output | 1 | 0 = tracking, 1 = seeking |
| searchRadius | output | RAD_W | Current search radius |
| panStep | output | POS_W | Signed pan step count |
| tiltStep | output | POS_W | Signed tilt step count |

## Verification
Every result of a frame is registered on the same edge that samples frameEnd, so all outputs are due exactly one cycle after the frameEnd beat. The bench drives inputs on falling edges. It pulses frameEnd for one cycle and compares every output at the next falling edge against a model built from the requirements. A reference written by one frame is observed through the choice and score outcome of the following frame. The init and reference loads are checked the same way, one cycle after their beats.

// File: rtl/hist_track_pkg.sv
package hist_track_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic frameClear;  // clear scores and window state
    logic refReplace;  // copy the winner's bins into the reference
  } dpStrobe_t;
endpackage

// File: rtl/hist_score_dp.sv
module hist_score_dp
  import hist_track_pkg::*;
#(
  parameter int NUM_WIN  = 4,
  parameter int NUM_BINS = 8,
  parameter int BIN_W    = 8,
  parameter int POS_W    = 12,
  localparam int WIN_W   = $clog2(NUM_WIN),
  localparam int IDX_W   = $clog2(NUM_BINS),
  localparam int SCORE_W = BIN_W + $clog2(NUM_BINS) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  dpStrobe_t                 strobe,
  input  logic                      refWrite,
  input  logic                      binValid,
  input  logic [WIN_W-1:0]          binWin,
  input  logic [IDX_W-1:0]          binIdx,
  input  logic [BIN_W-1:0]          binVal,
  input  logic [BIN_W-1:0]          binWeight,
  input  logic signed [POS_W-1:0]   binX,
  input  logic signed [POS_W-1:0]   binY,
  input  logic                      trainMode,
  output logic                      anySeen,
  output logic signed [SCORE_W-1:0] bestScore,
  output logic signed [POS_W-1:0]   bestX,
  output logic signed [POS_W-1:0]   bestY
);
  logic [BIN_W-1:0]          refMem  [NUM_BINS];
  logic [BIN_W-1:0]          histMem [NUM_WIN][NUM_BINS];
  logic signed [SCORE_W-1:0] score   [NUM_WIN];
  logic signed [POS_W-1:0]   winX    [NUM_WIN];
  logic signed [POS_W-1:0]   winY    [NUM_WIN];
  logic [NUM_WIN-1:0]        seen;
  logic [WIN_W-1:0]          bestId;

  // Contribution of the current beat
  logic [BIN_W-1:0]          refCur, absDiff;
  logic signed [SCORE_W-1:0] contrib;
  logic                      takeBin;

  always_comb begin
    refCur  = refMem[binIdx];
    absDiff = (binVal >= refCur) ? binVal - refCur : refCur - binVal;
    if (trainMode)
      contrib = (binVal <= refCur) ? SCORE_W'(binWeight) : -SCORE_W'(binWeight);
    else
      contrib = SCORE_W'(absDiff);
    takeBin = binValid && !refWrite && !strobe.frameClear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= '0;
      for (int w = 0; w < NUM_WIN; w++) begin
        score[w] <= '0;
        winX[w]  <= '0;
        winY[w]  <= '0;
        for (int b = 0; b < NUM_BINS; b++) histMem[w][b] <= '0;
      end
    end else if (strobe.frameClear) begin
      seen <= '0;
      for (int w = 0; w < NUM_WIN; w++) score[w] <= '0;
    end else if (takeBin) begin
      seen[binWin]            <= 1'b1;
      score[binWin]           <= score[binWin] + contrib;
      winX[binWin]            <= binX;
      winY[binWin]            <= binY;
      histMem[binWin][binIdx] <= binVal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BINS; b++) refMem[b] <= '0;
    end else if (strobe.refReplace) begin
      for (int b = 0; b < NUM_BINS; b++) refMem[b] <= histMem[bestId][b];
    end else if (binValid && refWrite && !strobe.frameClear) begin
      refMem[binIdx] <= binVal;
    end
  end

  // Minimum search: ascending ids with strict less-than keeps the lowest id on ties
  always_comb begin
    anySeen   = 1'b0;
    bestId    = '0;
    bestScore = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (seen[w] && (!anySeen || score[w] < bestScore)) begin
        anySeen   = 1'b1;
        bestId    = WIN_W'(w);
        bestScore = score[w];
      end
    end
    bestX = winX[bestId];
    bestY = winY[bestId];
  end

  // A window with no beat this frame still holds a zero score (R2)
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
    p_unseen_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !seen[w] |-> score[w] == '0);
  end

  // After a frame clear no window is a candidate (R9)
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.frameClear |=> seen == '0);
endmodule

// File: rtl/track_ctrl.sv
module track_ctrl
  import hist_track_pkg::*;
#(
  parameter int POS_W      = 12,
  parameter int BIN_W      = 8,
  parameter int NUM_BINS   = 8,
  parameter int STEP_SHIFT = 2,
  parameter int CENTER_X   = 64,
  parameter int CENTER_Y   = 48,
  parameter int BASE_R     = 4,
  parameter int INC_R      = 2,
  parameter int MAX_R      = 10,
  parameter int RAD_W      = 5,
  localparam int SCORE_W   = BIN_W + $clog2(NUM_BINS) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      initStrobe,
  input  logic signed [POS_W-1:0]   initX,
  input  logic signed [POS_W-1:0]   initY,
  input  logic                      frameEnd,
  input  logic                      trainMode,
  input  logic signed [SCORE_W-1:0] thresh,
  input  logic                      anySeen,
  input  logic signed [SCORE_W-1:0] bestScore,
  input  logic signed [POS_W-1:0]   bestX,
  input  logic signed [POS_W-1:0]   bestY,
  output dpStrobe_t                 strobe,
  output logic                      decValid,
  output logic signed [POS_W-1:0]   tgtX,
  output logic signed [POS_W-1:0]   tgtY,
  output logic signed [POS_W-1:0]   predX,
  output logic signed [POS_W-1:0]   predY,
  output logic                      searchMode,
  output logic [RAD_W-1:0]          searchRadius,
  output logic signed [POS_W-1:0]   panStep,
  output logic signed [POS_W-1:0]   tiltStep
);
  logic             frameEvt, accept;
  logic [RAD_W:0]   radSum;

  // Signed divide by 2^STEP_SHIFT, rounding toward zero
  function automatic logic signed [POS_W-1:0] toStep(input logic signed [POS_W:0] d);
    logic signed [POS_W:0] adj;
    adj = (d < 0) ? d + (POS_W+1)'((1 << STEP_SHIFT) - 1) : d;
    return POS_W'(adj >>> STEP_SHIFT);
  endfunction

  always_comb begin
    frameEvt          = frameEnd && !initStrobe;
    accept            = anySeen && (bestScore < thresh);
    radSum            = {1'b0, searchRadius} + (RAD_W+1)'(INC_R);
    strobe.frameClear = frameEnd || initStrobe;
    strobe.refReplace = frameEvt && accept && !trainMode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decValid     <= 1'b0;
      tgtX         <= '0;
      tgtY         <= '0;
      predX        <= '0;
      predY        <= '0;
      searchMode   <= 1'b0;
      searchRadius <= RAD_W'(BASE_R);
      panStep      <= '0;
      tiltStep     <= '0;
    end else begin
      decValid <= frameEvt;
      if (initStrobe) begin
        tgtX         <= initX;
        tgtY         <= initY;
        predX        <= initX;
        predY        <= initY;
        searchMode   <= 1'b0;
        searchRadius <= RAD_W'(BASE_R);
        panStep      <= '0;
        tiltStep     <= '0;
      end else if (frameEvt) begin
        if (accept) begin
          tgtX         <= bestX;
          tgtY         <= bestY;
          predX        <= bestX + (bestX - tgtX);
          predY        <= bestY + (bestY - tgtY);
          searchMode   <= 1'b0;
          searchRadius <= RAD_W'(BASE_R);
          panStep      <= toStep({bestX[POS_W-1], bestX} - (POS_W+1)'(CENTER_X));
          tiltStep     <= toStep({bestY[POS_W-1], bestY} - (POS_W+1)'(CENTER_Y));
        end else begin
          searchMode   <= 1'b1;
          searchRadius <= (radSum > (RAD_W+1)'(MAX_R)) ? RAD_W'(MAX_R) : radSum[RAD_W-1:0];
          panStep      <= '0;
          tiltStep     <= '0;
        end
      end
    end
  end

  p_result_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frameEnd && !initStrobe |=> decValid);
  p_track_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !searchMode |-> searchRadius == RAD_W'(BASE_R));
  p_radius_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    searchRadius <= RAD_W'(MAX_R));
  p_lost_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    decValid && searchMode |-> $stable(tgtX) && $stable(tgtY) && panStep == '0 && tiltStep == '0);
endmodule

// File: rtl/hist_track_top.sv
module hist_track_top
  import hist_track_pkg::*;
#(
  parameter int NUM_WIN    = 4,
  parameter int NUM_BINS   = 8,
  parameter int BIN_W      = 8,
  parameter int POS_W      = 12,
  parameter int STEP_SHIFT = 2,
  parameter int CENTER_X   = 64,
  parameter int CENTER_Y   = 48,
  parameter int BASE_R     = 4,
  parameter int INC_R      = 2,
  parameter int MAX_R      = 10,
  parameter int RAD_W      = 5,
  localparam int WIN_W     = $clog2(NUM_WIN),
  localparam int IDX_W     = $clog2(NUM_BINS),
  localparam int SCORE_W   = BIN_W + $clog2(NUM_BINS) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      initStrobe,
  input  logic signed [POS_W-1:0]   initX,
  input  logic signed [POS_W-1:0]   initY,
  input  logic                      refWrite,
  input  logic                      binValid,
  input  logic [WIN_W-1:0]          binWin,
  input  logic [IDX_W-1:0]          binIdx,
  input  logic [BIN_W-1:0]          binVal,
  input  logic [BIN_W-1:0]          binWeight,
  input  logic signed [POS_W-1:0]   binX,
  input  logic signed [POS_W-1:0]   binY,
  input  logic                      frameEnd,
  input  logic                      trainMode,
  input  logic signed [SCORE_W-1:0] thresh,
  output logic                      decValid,
  output logic signed [POS_W-1:0]   tgtX,
  output logic signed [POS_W-1:0]   tgtY,
  output logic signed [POS_W-1:0]   predX,
  output logic signed [POS_W-1:0]   predY,
  output logic                      searchMode,
  output logic [RAD_W-1:0]          searchRadius,
  output logic signed [POS_W-1:0]   panStep,
  output logic signed [POS_W-1:0]   tiltStep
);
  dpStrobe_t                 strobe;
  logic                      anySeen;
  logic signed [SCORE_W-1:0] bestScore;
  logic signed [POS_W-1:0]   bestX, bestY;

  hist_score_dp #(.NUM_WIN(NUM_WIN), .NUM_BINS(NUM_BINS), .BIN_W(BIN_W), .POS_W(POS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .refWrite(refWrite), .binValid(binValid),
    .binWin(binWin), .binIdx(binIdx), .binVal(binVal), .binWeight(binWeight),
    .binX(binX), .binY(binY), .trainMode(trainMode), .anySeen(anySeen),
    .bestScore(bestScore), .bestX(bestX), .bestY(bestY));

  track_ctrl #(.POS_W(POS_W), .BIN_W(BIN_W), .NUM_BINS(NUM_BINS), .STEP_SHIFT(STEP_SHIFT),
               .CENTER_X(CENTER_X), .CENTER_Y(CENTER_Y), .BASE_R(BASE_R), .INC_R(INC_R),
               .MAX_R(MAX_R), .RAD_W(RAD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .initStrobe(initStrobe), .initX(initX), .initY(initY),
    .frameEnd(frameEnd), .trainMode(trainMode), .thresh(thresh), .anySeen(anySeen),
    .bestScore(bestScore), .bestX(bestX), .bestY(bestY), .strobe(strobe),
    .decValid(decValid), .tgtX(tgtX), .tgtY(tgtY), .predX(predX), .predY(predY),
    .searchMode(searchMode), .searchRadius(searchRadius), .panStep(panStep),
    .tiltStep(tiltStep));
endmodule

// File: tb/hist_track_top_tb.sv
module hist_track_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4, NB = 8, CX = 64, CY = 48, BASE = 4, INC = 2, RMAX = 10;

  logic clk = 0, rst_n = 0;
  logic initStrobe = 0, refWrite = 0, binValid = 0, frameEnd = 0, trainMode = 0;
  logic signed [11:0] initX = 0, initY = 0, binX = 0, binY = 0;
  logic [1:0] binWin = 0;
  logic [2:0] binIdx = 0;
  logic [7:0] binVal = 0, binWeight = 0;
  logic signed [11:0] thresh = 0;
  logic decValid, searchMode;
  logic signed [11:0] tgtX, tgtY, predX, predY, panStep, tiltStep;
  logic [4:0] searchRadius;

  hist_track_top u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  int mref[NB], mh[NW][NB], mw[NB], mx[NW], my[NW];
  bit mseen[NW];
  int eTX, eTY, ePX, ePY, eMode, eRad, ePan, eTilt;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int stepOf(int d);
    return (d < 0) ? -((-d) >>> 2) : (d >>> 2);
  endfunction

  function automatic int scoreOf(int w);
    int s = 0;
    for (int b = 0; b < NB; b++)
      if (trainMode) s += (mh[w][b] <= mref[b]) ? mw[b] : -mw[b];
      else s += (mh[w][b] > mref[b]) ? mh[w][b] - mref[b] : mref[b] - mh[w][b];
    return s;
  endfunction

  task automatic idle();
    @(negedge clk);
    binValid = 0; refWrite = 0; frameEnd = 0; initStrobe = 0;
  endtask

  task automatic checkAll(string req);
    chk(req, "tgtX", int'(tgtX), eTX);   chk(req, "tgtY", int'(tgtY), eTY);
    chk(req, "predX", int'(predX), ePX); chk(req, "predY", int'(predY), ePY);
    chk(req, "mode", int'(searchMode), eMode); chk(req, "radius", int'(searchRadius), eRad);
    chk(req, "pan", int'(panStep), ePan);      chk(req, "tilt", int'(tiltStep), eTilt);
  endtask

  task automatic loadRef();
    for (int b = 0; b < NB; b++) begin
      @(negedge clk);
      binValid = 1; refWrite = 1; binIdx = 3'(b); binVal = 8'(mref[b]);
    end
    idle();
  endtask

  task automatic doInit(int x, int y);
    @(negedge clk);
    binValid = 0; initStrobe = 1; initX = 12'(x); initY = 12'(y);
    @(negedge clk); initStrobe = 0;
    eTX = x; eTY = y; ePX = x; ePY = y; eMode = 0; eRad = BASE; ePan = 0; eTilt = 0;
    checkAll("R10");
  endtask

  task automatic sendWin(int w, int x, int y);
    for (int b = 0; b < NB; b++) begin
      @(negedge clk);
      binValid = 1; refWrite = 0; binWin = 2'(w); binIdx = 3'(b);
      binVal = 8'(mh[w][b]); binWeight = 8'(mw[b]); binX = 12'(x); binY = 12'(y);
    end
    mseen[w] = 1; mx[w] = x; my[w] = y;
  endtask

  // junkBin: drive a bin beat during the frameEnd cycle (must be ignored)
  task automatic endFrame(string req, int thr, bit junkBin);
    int best = -1, bs = 0, s;
    for (int w = 0; w < NW; w++)
      if (mseen[w]) begin
        s = scoreOf(w);
        if (best < 0 || s < bs) begin best = w; bs = s; end
      end
    @(negedge clk);
    thresh = 12'(thr); frameEnd = 1; binValid = junkBin; refWrite = 0;
    binWin = 0; binVal = 8'(mref[0]); binIdx = 0;
    @(negedge clk);
    frameEnd = 0; binValid = 0;
    if (best >= 0 && bs < thr) begin
      ePX = 2 * mx[best] - eTX; ePY = 2 * my[best] - eTY;
      eTX = mx[best]; eTY = my[best]; eMode = 0; eRad = BASE;
      ePan = stepOf(eTX - CX); eTilt = stepOf(eTY - CY);
      if (!trainMode) for (int b = 0; b < NB; b++) mref[b] = mh[best][b];
    end else begin
      eMode = 1; eRad = (eRad + INC > RMAX) ? RMAX : eRad + INC; ePan = 0; eTilt = 0;
    end
    chk("R9", "decValid", int'(decValid), 1);
    checkAll(req);
    for (int w = 0; w < NW; w++) mseen[w] = 0;
  endtask

  function automatic int near(int v);
    int r = v + int'($urandom_range(0, 20)) - 10;
    return (r < 0) ? 0 : (r > 255 ? 255 : r);
  endfunction

  initial begin
    void'($urandom(32'd2024));
    for (int b = 0; b < NB; b++) begin
      mref[b] = int'($urandom_range(20, 200)); mw[b] = int'($urandom_range(1, 30));
    end
    for (int w = 0; w < NW; w++) mseen[w] = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "decValid", int'(decValid), 0); chk("R10", "tgtX", int'(tgtX), 0);
    chk("R10", "mode", int'(searchMode), 0);   chk("R10", "radius", int'(searchRadius), BASE);
    rst_n = 1;
    loadRef();
    doInit(70, 40);

    // R2 tie: windows 1 and 2 score 1, lowest id wins; R6/R7 on result
    for (int w = 0; w < NW; w++) for (int b = 0; b < NB; b++) mh[w][b] = mref[b];
    for (int b = 0; b < NB; b++) begin mh[0][b] = mref[b] + 3; mh[3][b] = mref[b] + 40; end
    mh[1][2] = mref[2] + 1; mh[2][5] = mref[5] - 1;
    sendWin(0, 90, 60); sendWin(1, 74, 44); sendWin(2, 80, 50); sendWin(3, 10, 10);
    endFrame("R2", 100, 0);
    chk("R6", "predX tie", int'(predX), 78);
    chk("R7", "tilt tie", int'(tiltStep), -1);

    // R4: next frame scores against the replaced reference (mh[1])
    for (int b = 0; b < NB; b++) begin mh[0][b] = mh[1][b] - 1; mh[1][b] = mref[b]; end
    mh[0][0] = mref[0];
    sendWin(0, 66, 46); sendWin(1, 77, 47);
    endFrame("R4", 5, 0);
    chk("R4", "winner x", int'(tgtX), 77);

    // R1/R3 threshold boundary: equal score rejects, one more accepts
    for (int b = 0; b < NB; b++) mh[2][b] = near(mref[b]);
    sendWin(2, 57, 55);
    endFrame("R3", scoreOf(2), 0);
    chk("R3", "reject at equal", int'(searchMode), 1);
    sendWin(2, 57, 55);
    endFrame("R1", scoreOf(2) + 1, 0);
    chk("R7", "pan neg round", int'(panStep), -1);

    // R5: lost frames with no windows, radius grows and saturates
    for (int i = 0; i < 5; i++) endFrame("R5", 2000, 0);
    chk("R5", "radius sat", int'(searchRadius), RMAX);

    // R2: only window 3 present, recapture R3
    for (int b = 0; b < NB; b++) mh[3][b] = mref[b] + 2;
    sendWin(3, 61, 49);
    endFrame("R2", 100, 0);
    chk("R3", "recapture", int'(searchRadius), BASE);

    // R9: bin beat in frameEnd cycle ignored -> next empty frame is lost
    endFrame("R5", 2000, 1);
    endFrame("R9", 2000, 0);

    // R8 trained mode, then normal frame verifies reference kept
    trainMode = 1;
    for (int w = 0; w < 3; w++) for (int b = 0; b < NB; b++) mh[w][b] = near(mref[b]);
    sendWin(0, 60, 40); sendWin(1, 68, 52); sendWin(2, 50, 30);
    endFrame("R8", 0, 0);
    trainMode = 0;
    for (int b = 0; b < NB; b++) mh[0][b] = near(mref[b]);
    sendWin(0, 65, 45);
    endFrame("R8", scoreOf(0) + 1, 0);

    // Random frames
    for (int f = 0; f < 40; f++) begin
      int thr;
      trainMode = ($urandom_range(0, 3) == 0);
      for (int w = 0; w < NW; w++) begin
        if ($urandom_range(0, 3) != 0) begin
          for (int b = 0; b < NB; b++) mh[w][b] = near(mref[b]);
          sendWin(w, int'($urandom_range(0, 160)) - 16, int'($urandom_range(0, 120)) - 12);
        end
      end
      thr = trainMode ? int'($urandom_range(0, 300)) - 150 : int'($urandom_range(0, 60));
      endFrame("R1", thr, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule